// File: doc/BRIEF.md
# Processor Debug Event Status Unit

This unit sits next to a processor pipeline and turns four pipeline strobes into debug status. The strobes are: an instruction completed, a non-critical interrupt was taken, a critical interrupt was taken, and a return-from-interrupt was attempted. Each strobe carries its own address. Per-event enable bits and the machine-state debug-enable level decide which strobes count. A counted strobe sets a sticky status bit and loads the debug save register with an address that depends on the event class. Some events are counted while debug interrupts are masked. Those events, and a completion that also raised a rounding exception, set an extra imprecise flag.

Software clears the status bits through a write-one-to-clear port. The debug interrupt request is derived from the status bits at all times. It is raised while debug is enabled and no higher-priority exception is pending.

Top module: `dbg_event_unit`

## Requirements
- R1: While `rstN` is low and just after it rises, `status` is 0, `saveAddr` is 0 and `dbgIrq` is 0.
- R2: Bit 1 of `status` is the interrupt-taken bit. When `irqStb` and `ctlEn[1]` are high at a clock edge, bit 1 is set whatever the value of `debugEn`, and `saveAddr` takes `irqVec`.
- R3: Bit 2 of `status` is the critical-taken bit. When `critStb` and `ctlEn[2]` are high at a clock edge, bit 2 is set whatever the value of `debugEn`, and `saveAddr` takes `critVec`.
- R4: Bit 3 of `status` is the return bit and bit 4 is the imprecise flag. When `retStb` and `ctlEn[3]` are high, bit 3 is set and `saveAddr` takes `retPc`. Bit 4 is also set when `debugEn` is 0 in that cycle.
- R5: Bit 0 of `status` is the instruction-complete bit. When `complStb`, `ctlEn[0]` and `debugEn` are all high, bit 0 is set and `saveAddr` takes `complNextPc`. With `debugEn` low the strobe changes neither `status` nor `saveAddr`.
- R6: A completion with `complSetsDe` high changes neither `status` nor `saveAddr`.
- R7: A recognized completion with `complRound` high sets bits 0 and 4, and `saveAddr` takes `roundVec`.
- R8: A strobe whose `ctlEn` bit is 0 changes neither `status` nor `saveAddr`.
- R9: Status bits are sticky. When `clrWr` is high, each `status` bit whose `clrMask` bit is 1 is cleared at the edge. A clear and a new set of the same bit in the same cycle leave the bit set.
- R10: `dbgIrq` is high exactly when `debugEn` is 1, `higherPending` is 0 and any of `status[3:0]` is 1. It follows these inputs in the same cycle.
- R11: When several events are recognized in one cycle, `saveAddr` is loaded in this order of precedence: critical, interrupt, return, completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| debugEn | input | 1 | Machine-state debug-enable level |
| ctlEn | input | 4 | Event enables: [0] completion, [1] interrupt, [2] critical, [3] return |
| higherPending | input | 1 | A higher-priority enabled exception is pending |
| complStb | input | 1 | Instruction completed |
| complSetsDe | input | 1 | The completing instruction sets debug-enable |
| complRound | input | 1 | The completing instruction raised a rounding exception |
| complNextPc | input | ADDR_W | Address of the next instruction |
| roundVec | input | ADDR_W | Rounding exception handler address |
| irqStb | input | 1 | Non-critical interrupt taken |
| irqVec | input | ADDR_W | Non-critical handler address |
| critStb | input | 1 | Critical interrupt taken |
| critVec | input | ADDR_W | Critical handler address |
| retStb | input | 1 | Return-from-interrupt attempted |
| retPc | input | ADDR_W | Address of the return instruction |
| clrWr | input | 1 | Status clear write strobe |
| clrMask | input | 5 | Write-one-to-clear mask for `status` |
| status | output | 5 | Sticky status: [0] completion, [1] interrupt, [2] critical, [3] return, [4] imprecise |
| saveAddr | output | ADDR_W | Debug save register 0 |
| dbgIrq | output | 1 | Debug interrupt request |

## Verification
A wrong status bit shows on `status` at the first sampling after the edge that should have set or cleared it. Through `dbgIrq` it shows in the same cycle, whenever debug is enabled and nothing of higher priority is pending. A wrong selection or priority shows on `saveAddr` one edge after the cycle with several events. Because the bits are sticky, a spurious set stays visible until software clears it. A lost set stays missing for the rest of the run, so the bench's cycle-by-cycle model comparison catches either case at the next sample.

// File: rtl/dbg_event_pkg.sv
package dbg_event_pkg;
  localparam int EVT_N   = 4;
  localparam int STAT_W  = EVT_N + 1;
  localparam int B_CMPL  = 0;
  localparam int B_IRQ   = 1;
  localparam int B_CRIT  = 2;
  localparam int B_RET   = 3;
  localparam int B_IMP   = 4;

  typedef enum logic [2:0] {
    SEL_CMPL  = 3'd0,
    SEL_ROUND = 3'd1,
    SEL_RET   = 3'd2,
    SEL_IRQ   = 3'd3,
    SEL_CRIT  = 3'd4
  } addr_sel_e;

  typedef struct packed {
    logic [EVT_N-1:0] hit;
    logic             imprecise;
    logic             load;
    addr_sel_e        sel;
  } evt_strb_t;
endpackage

// File: rtl/dbg_event_ctl.sv
module dbg_event_ctl
  import dbg_event_pkg::*;
(
  input  logic                   debugEn,
  input  logic [EVT_N-1:0]       ctlEn,
  input  logic                   higherPending,
  input  logic                   complStb,
  input  logic                   complSetsDe,
  input  logic                   complRound,
  input  logic                   irqStb,
  input  logic                   critStb,
  input  logic                   retStb,
  input  logic [STAT_W-1:0]      status,
  output evt_strb_t              strb,
  output logic                   dbgIrq
);
  logic cmplHit, irqHit, critHit, retHit;

  always_comb begin
    cmplHit = complStb & ctlEn[B_CMPL] & debugEn & ~complSetsDe;
    irqHit  = irqStb   & ctlEn[B_IRQ];
    critHit = critStb  & ctlEn[B_CRIT];
    retHit  = retStb   & ctlEn[B_RET];
  end

  always_comb begin
    strb.hit       = '0;
    strb.hit[B_CMPL] = cmplHit;
    strb.hit[B_IRQ]  = irqHit;
    strb.hit[B_CRIT] = critHit;
    strb.hit[B_RET]  = retHit;
    strb.imprecise = (retHit & ~debugEn) | (cmplHit & complRound);
    strb.load      = cmplHit | irqHit | critHit | retHit;
    if (critHit)      strb.sel = SEL_CRIT;
    else if (irqHit)  strb.sel = SEL_IRQ;
    else if (retHit)  strb.sel = SEL_RET;
    else if (complRound) strb.sel = SEL_ROUND;
    else              strb.sel = SEL_CMPL;
  end

  assign dbgIrq = debugEn & ~higherPending & (|status[EVT_N-1:0]);
endmodule

// File: rtl/dbg_event_dp.sv
module dbg_event_dp
  import dbg_event_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  evt_strb_t          strb,
  input  logic               clrWr,
  input  logic [STAT_W-1:0]  clrMask,
  input  logic [ADDR_W-1:0]  complNextPc,
  input  logic [ADDR_W-1:0]  roundVec,
  input  logic [ADDR_W-1:0]  irqVec,
  input  logic [ADDR_W-1:0]  critVec,
  input  logic [ADDR_W-1:0]  retPc,
  output logic [STAT_W-1:0]  status,
  output logic [ADDR_W-1:0]  saveAddr
);
  logic [STAT_W-1:0] setVec;
  logic [STAT_W-1:0] clrVec;
  logic [ADDR_W-1:0] addrNext;

  assign setVec = {strb.imprecise, strb.hit};
  assign clrVec = clrWr ? clrMask : '0;

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rstN) status[i] <= 1'b0;
      else       status[i] <= (status[i] & ~clrVec[i]) | setVec[i];
    end
  end

  always_comb begin
    unique case (strb.sel)
      SEL_CRIT:  addrNext = critVec;
      SEL_IRQ:   addrNext = irqVec;
      SEL_RET:   addrNext = retPc;
      SEL_ROUND: addrNext = roundVec;
      default:   addrNext = complNextPc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          saveAddr <= '0;
    else if (strb.load) saveAddr <= addrNext;
  end
endmodule

// File: rtl/dbg_event_unit.sv
module dbg_event_unit
  import dbg_event_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              debugEn,
  input  logic [3:0]        ctlEn,
  input  logic              higherPending,
  input  logic              complStb,
  input  logic              complSetsDe,
  input  logic              complRound,
  input  logic [ADDR_W-1:0] complNextPc,
  input  logic [ADDR_W-1:0] roundVec,
  input  logic              irqStb,
  input  logic [ADDR_W-1:0] irqVec,
  input  logic              critStb,
  input  logic [ADDR_W-1:0] critVec,
  input  logic              retStb,
  input  logic [ADDR_W-1:0] retPc,
  input  logic              clrWr,
  input  logic [4:0]        clrMask,
  output logic [4:0]        status,
  output logic [ADDR_W-1:0] saveAddr,
  output logic              dbgIrq
);
  evt_strb_t strb;

  dbg_event_ctl u_ctl (
    .debugEn(debugEn), .ctlEn(ctlEn), .higherPending(higherPending),
    .complStb(complStb), .complSetsDe(complSetsDe), .complRound(complRound),
    .irqStb(irqStb), .critStb(critStb), .retStb(retStb),
    .status(status), .strb(strb), .dbgIrq(dbgIrq)
  );

  dbg_event_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .clrWr(clrWr), .clrMask(clrMask),
    .complNextPc(complNextPc), .roundVec(roundVec), .irqVec(irqVec),
    .critVec(critVec), .retPc(retPc), .status(status), .saveAddr(saveAddr)
  );
endmodule

// File: rtl/dbg_event_unit_chk.sv
module dbg_event_unit_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              debugEn,
  input logic [3:0]        ctlEn,
  input logic              higherPending,
  input logic              complStb,
  input logic              irqStb,
  input logic              critStb,
  input logic [ADDR_W-1:0] critVec,
  input logic              retStb,
  input logic              clrWr,
  input logic [4:0]        clrMask,
  input logic [4:0]        status,
  input logic [ADDR_W-1:0] saveAddr,
  input logic              dbgIrq
);
  p_crit_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    (critStb && ctlEn[2]) |=> (status[2] && saveAddr == $past(critVec)));

  p_irq_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    (irqStb && ctlEn[1]) |=> status[1]);

  p_ret_imprecise_r4: assert property (@(posedge clk) disable iff (!rstN)
    (retStb && ctlEn[3] && !debugEn) |=> (status[3] && status[4]));

  p_cmpl_masked_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[0]) |-> $past(complStb && debugEn && ctlEn[0]));

  p_sticky_ret_r9: assert property (@(posedge clk) disable iff (!rstN)
    (status[3] && !(clrWr && clrMask[3])) |=> status[3]);

  p_sticky_imp_r9: assert property (@(posedge clk) disable iff (!rstN)
    (status[4] && !(clrWr && clrMask[4])) |=> status[4]);

  p_req_masked_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!debugEn || higherPending) |-> !dbgIrq);

  p_req_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (status[3:0] == 4'b0) |-> !dbgIrq);
endmodule

bind dbg_event_unit dbg_event_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .debugEn(debugEn), .ctlEn(ctlEn),
  .higherPending(higherPending), .complStb(complStb), .irqStb(irqStb),
  .critStb(critStb), .critVec(critVec), .retStb(retStb), .clrWr(clrWr),
  .clrMask(clrMask), .status(status), .saveAddr(saveAddr), .dbgIrq(dbgIrq)
);

// File: tb/dbg_event_unit_test.sv
module dbg_event_unit_test;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic debugEn = 0, higherPending = 0;
  logic [3:0] ctlEn = 0;
  logic complStb = 0, complSetsDe = 0, complRound = 0;
  logic irqStb = 0, critStb = 0, retStb = 0, clrWr = 0;
  logic [4:0] clrMask = 0;
  logic [AW-1:0] complNextPc = 0, roundVec = 0, irqVec = 0, critVec = 0, retPc = 0;
  logic [4:0] status;
  logic [AW-1:0] saveAddr;
  logic dbgIrq;

  int checks = 0;
  int failures = 0;
  logic done = 0;
  logic [4:0] expStatus = 0;
  logic [AW-1:0] expAddr = 0;

  always #5 clk = ~clk;

  dbg_event_unit #(.ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .debugEn(debugEn), .ctlEn(ctlEn),
    .higherPending(higherPending), .complStb(complStb), .complSetsDe(complSetsDe),
    .complRound(complRound), .complNextPc(complNextPc), .roundVec(roundVec),
    .irqStb(irqStb), .irqVec(irqVec), .critStb(critStb), .critVec(critVec),
    .retStb(retStb), .retPc(retPc), .clrWr(clrWr), .clrMask(clrMask),
    .status(status), .saveAddr(saveAddr), .dbgIrq(dbgIrq)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic expReq(logic [4:0] st);
    return debugEn && !higherPending && (st[3:0] != 4'b0);
  endfunction

  task automatic modelEdge();
    logic c, i, k, r;
    logic [4:0] setv;
    c = complStb && ctlEn[0] && debugEn && !complSetsDe;
    i = irqStb && ctlEn[1];
    k = critStb && ctlEn[2];
    r = retStb && ctlEn[3];
    setv = {(r && !debugEn) || (c && complRound), r, k, i, c};
    expStatus = (expStatus & ~(clrWr ? clrMask : 5'b0)) | setv;
    if (k) expAddr = critVec;
    else if (i) expAddr = irqVec;
    else if (r) expAddr = retPc;
    else if (c) expAddr = complRound ? roundVec : complNextPc;
  endtask

  // Called just after a falling edge with inputs already driven.
  task automatic step(string tag);
    #1;
    chk({tag, " R10 dbgIrq"}, dbgIrq, expReq(expStatus));
    modelEdge();
    @(posedge clk);
    #1;
    chk({tag, " status"}, status, expStatus);
    chk({tag, " saveAddr"}, saveAddr, expAddr);
    @(negedge clk);
    complStb = 0; complSetsDe = 0; complRound = 0;
    irqStb = 0; critStb = 0; retStb = 0; clrWr = 0; clrMask = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    irqVec = 32'h0000_0500; critVec = 32'h0000_0100; retPc = 32'h0000_2A40;
    complNextPc = 32'h0000_3004; roundVec = 32'h0000_0800;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 status in reset", status, 0);
    chk("R1 saveAddr in reset", saveAddr, 0);
    chk("R1 dbgIrq in reset", dbgIrq, 0);
    rstN = 1;
    @(negedge clk);
    chk("R1 status after reset", status, 0);

    // R2: interrupt taken while debug is masked
    ctlEn = 4'hF; debugEn = 0; irqStb = 1;
    step("R2 irq masked");
    chk("R2 literal status", status, 5'h02);
    chk("R2 literal addr", saveAddr, 32'h500);
    chk("R10 masked request", dbgIrq, 0);
    debugEn = 1; #1;
    chk("R10 enabled request", dbgIrq, 1);
    higherPending = 1; #1;
    chk("R10 higher pending blocks", dbgIrq, 0);
    higherPending = 0;

    // R9: write-one-to-clear
    clrWr = 1; clrMask = 5'h1F;
    step("R9 clear all");
    chk("R9 literal cleared", status, 0);

    // R11 and R3: simultaneous events, critical wins
    critStb = 1; irqStb = 1; retStb = 1; complStb = 1;
    step("R11 all at once");
    chk("R11 literal addr", saveAddr, 32'h100);
    chk("R3 literal status", status, 5'h0F);
    irqStb = 1; retStb = 1; complStb = 1;
    step("R11 irq beats return");
    chk("R11 irq addr", saveAddr, 32'h500);
    clrWr = 1; clrMask = 5'h1F; step("R9 clear");

    // R4: return with debug masked, then enabled
    debugEn = 0; retStb = 1;
    step("R4 ret masked");
    chk("R4 literal status", status, 5'h18);
    chk("R4 literal addr", saveAddr, 32'h2A40);
    clrWr = 1; clrMask = 5'h1F; step("R9 clear");
    debugEn = 1; retStb = 1;
    step("R4 ret enabled");
    chk("R4 no imprecise", status, 5'h08);
    clrWr = 1; clrMask = 5'h1F; step("R9 clear");

    // R5: completion gated by debug-enable
    debugEn = 0; complStb = 1;
    step("R5 cmpl masked");
    chk("R5 masked no status", status, 0);
    debugEn = 1; complStb = 1;
    step("R5 cmpl enabled");
    chk("R5 literal status", status, 5'h01);
    chk("R5 literal addr", saveAddr, 32'h3004);
    clrWr = 1; clrMask = 5'h1F; step("R9 clear");

    // R6: instruction that sets debug-enable
    complStb = 1; complSetsDe = 1;
    step("R6 sets-de suppressed");
    chk("R6 no status", status, 0);
    chk("R6 addr unchanged", saveAddr, 32'h3004);

    // R7: completion with rounding exception
    complStb = 1; complRound = 1;
    step("R7 round");
    chk("R7 literal status", status, 5'h11);
    chk("R7 literal addr", saveAddr, 32'h800);
    clrWr = 1; clrMask = 5'h1F; step("R9 clear");

    // R8: enables off
    ctlEn = 4'h0; critStb = 1; irqStb = 1; retStb = 1; complStb = 1;
    step("R8 disabled");
    chk("R8 no status", status, 0);
    chk("R8 addr unchanged", saveAddr, 32'h800);
    ctlEn = 4'hF;

    // R9: clear and set same cycle -> set
    irqStb = 1; step("R9 set irq");
    irqStb = 1; clrWr = 1; clrMask = 5'h02;
    step("R9 clear vs set");
    chk("R9 set wins", status[1], 1);
    clrWr = 1; clrMask = 5'h02; step("R9 partial clear");
    chk("R9 partial cleared", status, 0);

    // Random mix against the model (R2 R3 R4 R5 R7 R9 R10 R11)
    for (int n = 0; n < 400; n++) begin
      debugEn = $urandom_range(0, 3) != 0;
      higherPending = $urandom_range(0, 4) == 0;
      ctlEn = 4'($urandom);
      complStb = $urandom_range(0, 2) == 0;
      complSetsDe = $urandom_range(0, 5) == 0;
      complRound = $urandom_range(0, 4) == 0;
      irqStb = $urandom_range(0, 3) == 0;
      critStb = $urandom_range(0, 4) == 0;
      retStb = $urandom_range(0, 3) == 0;
      clrWr = $urandom_range(0, 2) == 0;
      clrMask = 5'($urandom);
      complNextPc = $urandom; roundVec = $urandom; irqVec = $urandom;
      critVec = $urandom; retPc = $urandom;
      step("R11 random model");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule